// File: doc/BRIEF.md
# Timestamp Capture FIFO Pair

This block stores the hardware timestamps of detected precision-time event frames in two independent queues, one for the receive direction and one for the transmit direction. Whenever the upstream classifier sees an event frame it pulses a capture strobe for that direction, together with a 30-bit nanoseconds value, a 32-bit seconds value and the frame's 16-bit sequence identifier. The block queues that triple until software collects it.

Software reaches the block through a small 16-bit register port. Each queue's oldest entry is shown as five words. Reading the last word of an entry, the sequence identifier, removes that entry from the queue. Software can therefore empty a queue by reading that word as many times as the queue depth. A count register reports how many entries each queue holds. An interrupt status register has data-available and overflow sources for each direction, and an enable register masks them into one interrupt line. A hard-reset command empties both queues and clears the status.

Top module: `ts_fifo_pair`

## Requirements
- R1: Each direction has its own first-in first-out queue of DEPTH entries. Entries come out in capture order, and captures or reads in one direction never change the other.
- R2: The head-entry words are at these addresses, receive first and then transmit: 0/5 nanoseconds high, 1/6 nanoseconds low, 2/7 seconds high, 3/8 seconds low, 4/9 sequence identifier.
  - The nanoseconds-high word holds ns[29:16] in bits 13:0, the valid flag in bit 15 and 0 in bit 14.
  - The other words hold ns[15:0], sec[31:16], sec[15:0] and seq[15:0].
- R3: The valid flag is 1 exactly when that queue is not empty. When the queue is empty, all five of its words read as zero.
- R4: A read of address 4 (receive) or 9 (transmit) removes the head entry if the queue is not empty. A read of any other head word changes nothing. A read of the sequence word of an empty queue changes nothing.
- R5: Address 12 reads the receive count in bits 7:0 and the transmit count in bits 15:8.
- R6: A capture into a full queue is dropped, and the queue contents stay unchanged. The drop sets a sticky overflow bit: status bit 2 for receive, status bit 3 for transmit.
- R7: Address 10 is the status register.
  - Bits 0 (receive) and 1 (transmit) are data-available bits. Each equals "queue not empty".
  - Reading the register clears both overflow bits. An overflow in the same cycle as the read leaves its bit set.
- R8: Address 11 is a read/write enable register, bits 3:0, with the same bit order as the status register. The irq output is high when any status bit and its enable bit are both 1.
- R9: A write to address 13 with bit 0 set empties both queues and clears the overflow bits in one cycle. This write wins over a capture in the same cycle and leaves the enable register unchanged.
- R10: After reset both counts are 0, the status and enable registers are 0, and irq is low.
- R11: A capture and a head removal may occur in the same cycle on one queue.
  - If the queue is not full, both take effect and the count is unchanged.
  - If the queue is full, the full check is made before the removal, so the capture is dropped and sets overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_cap | input | 1 | Receive capture strobe |
| rx_ns | input | 30 | Receive nanoseconds value |
| rx_sec | input | 32 | Receive seconds value |
| rx_seq | input | 16 | Receive sequence identifier |
| tx_cap | input | 1 | Transmit capture strobe |
| tx_ns | input | 30 | Transmit nanoseconds value |
| tx_sec | input | 32 | Transmit seconds value |
| tx_seq | input | 16 | Transmit sequence identifier |
| reg_addr | input | 4 | Register word address |
| reg_rd | input | 1 | Read strobe (side effects at the clock edge) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr, combinational |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench builds the block with DEPTH set to 4. With that depth, a full queue, a dropped capture and a pointer wrap are each reached after only a handful of captures. This makes it cheap to exercise an overflow while a removal happens in the same cycle, to run several fill and drain rounds, and to empty a queue completely. A reference queue per direction predicts every head word, every count and every status bit. It also checks that the two directions never disturb each other.

// File: rtl/ts_fifo_pair.sv
module ts_fifo_pair #(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_cap,
  input  logic [29:0] rx_ns,
  input  logic [31:0] rx_sec,
  input  logic [15:0] rx_seq,
  input  logic        tx_cap,
  input  logic [29:0] tx_ns,
  input  logic [31:0] tx_sec,
  input  logic [15:0] tx_seq,
  input  logic [3:0]  reg_addr,
  input  logic        reg_rd,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        irq
);
  localparam int ENT_W = 78;
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [3:0] A_STAT = 4'd10;
  localparam logic [3:0] A_EN   = 4'd11;
  localparam logic [3:0] A_CNT  = 4'd12;
  localparam logic [3:0] A_CTRL = 4'd13;

  logic [1:0]            cap, push, pop, full, nonempty, drop;
  logic [1:0][ENT_W-1:0] cap_ent, head;
  logic [1:0][CNT_W-1:0] cnt;
  logic [1:0]            ovf_q;
  logic [3:0]            en_q;
  logic [3:0]            status;
  logic                  hard_rst, stat_rd;
  logic                  unused_wdata;

  assign cap        = {tx_cap, rx_cap};
  assign cap_ent[0] = {rx_ns, rx_sec, rx_seq};
  assign cap_ent[1] = {tx_ns, tx_sec, tx_seq};
  assign hard_rst   = reg_wr && reg_addr == A_CTRL && reg_wdata[0];
  assign stat_rd    = reg_rd && reg_addr == A_STAT;
  assign unused_wdata = ^reg_wdata[15:4];

  for (genvar d = 0; d < 2; d++) begin : g_dir
    logic [ENT_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;

    assign full[d]     = cnt[d] == CNT_W'(DEPTH);
    assign nonempty[d] = cnt[d] != '0;
    assign push[d]     = cap[d] && !full[d] && !hard_rst;
    assign drop[d]     = cap[d] && full[d] && !hard_rst;
    assign pop[d]      = reg_rd && reg_addr == 4'(4 + 5 * d) && nonempty[d] && !hard_rst;
    assign head[d]     = mem[rptr];

    always_ff @(posedge clk)
      if (push[d]) mem[wptr] <= cap_ent[d];

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        wptr   <= '0;
        rptr   <= '0;
        cnt[d] <= '0;
      end else if (hard_rst) begin
        wptr   <= '0;
        rptr   <= '0;
        cnt[d] <= '0;
      end else begin
        if (push[d]) wptr <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
        if (pop[d])  rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
        cnt[d] <= cnt[d] + CNT_W'(push[d]) - CNT_W'(pop[d]);
      end

    a_r6_full_drop_sets_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      (cap[d] && full[d] && !hard_rst) |=> (ovf_q[d] && cnt[d] != '0));
    a_r4_pop_decrements: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == 4'(4 + 5 * d) && nonempty[d] && !cap[d] && !hard_rst)
      |=> cnt[d] == CNT_W'($past(cnt[d]) - 1'b1));
    a_r11_both_keep_count: assert property (@(posedge clk) disable iff (!rst_n)
      (pop[d] && cap[d] && !full[d]) |=> $stable(cnt[d]));
    a_r1_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[d] <= CNT_W'(DEPTH));
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_q <= '0;
      en_q  <= '0;
    end else begin
      ovf_q <= hard_rst ? 2'b00 : ((stat_rd ? 2'b00 : ovf_q) | drop);
      if (reg_wr && reg_addr == A_EN) en_q <= reg_wdata[3:0];
    end

  assign status = {ovf_q, nonempty};
  assign irq    = |(status & en_q);

  function automatic logic [15:0] head_word(input logic [ENT_W-1:0] e, input logic v,
                                            input logic [2:0] w);
    logic [15:0] r;
    case (w)
      3'd0:    r = {1'b1, 1'b0, e[77:64]};
      3'd1:    r = e[63:48];
      3'd2:    r = e[47:32];
      3'd3:    r = e[31:16];
      default: r = e[15:0];
    endcase
    return v ? r : 16'h0000;
  endfunction

  always_comb begin
    reg_rdata = 16'h0000;
    case (reg_addr)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4:
        reg_rdata = head_word(head[0], nonempty[0], 3'(reg_addr));
      4'd5, 4'd6, 4'd7, 4'd8, 4'd9:
        reg_rdata = head_word(head[1], nonempty[1], 3'(reg_addr - 4'd5));
      A_STAT:  reg_rdata = {12'h000, status};
      A_EN:    reg_rdata = {12'h000, en_q};
      A_CNT:   reg_rdata = {8'(cnt[1]), 8'(cnt[0])};
      default: reg_rdata = 16'h0000;
    endcase
  end

  a_r9_hard_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
    hard_rst |=> (cnt == '0 && ovf_q == 2'b00));
  a_r7_read_clears_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && drop == 2'b00) |=> ovf_q == 2'b00);
  a_r8_irq_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 4'h0) |-> !irq);
endmodule

// File: tb/ts_fifo_pair_test.sv
`timescale 1ns/1ps
module ts_fifo_pair_test;
  localparam int DEPTH = 4;

  logic        clk = 0, rst_n = 0;
  logic        rx_cap = 0, tx_cap = 0;
  logic [29:0] rx_ns = 0, tx_ns = 0;
  logic [31:0] rx_sec = 0, tx_sec = 0;
  logic [15:0] rx_seq = 0, tx_seq = 0;
  logic [3:0]  reg_addr = 0;
  logic        reg_rd = 0, reg_wr = 0;
  logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic        irq;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [77:0] q_rx[$], q_tx[$];
  bit [1:0] ovf = 0;
  logic [3:0] en = 0;

  always #4 clk = ~clk;

  ts_fifo_pair #(.DEPTH(DEPTH)) uut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic int qsize(input int d);
    return d == 0 ? q_rx.size() : q_tx.size();
  endfunction

  function automatic logic [77:0] qfront(input int d);
    if (d == 0) return q_rx.size() > 0 ? q_rx[0] : '0;
    return q_tx.size() > 0 ? q_tx[0] : '0;
  endfunction

  function automatic logic [15:0] exp_word(input int d, input int w);
    logic [77:0] e = qfront(d);
    if (qsize(d) == 0) return 16'h0;
    case (w)
      0: return {2'b10, e[77:64]};
      1: return e[63:48];
      2: return e[47:32];
      3: return e[31:16];
      default: return e[15:0];
    endcase
  endfunction

  function automatic logic [3:0] exp_status();
    return {ovf, qsize(1) != 0, qsize(0) != 0};
  endfunction

  task automatic model_cap(input int d, input logic [77:0] e, input int size_before);
    if (size_before >= DEPTH) ovf[d] = 1;
    else if (d == 0) q_rx.push_back(e);
    else q_tx.push_back(e);
  endtask

  task automatic drive_cap(input int d, input logic [77:0] e);
    if (d == 0) begin rx_cap = 1; {rx_ns, rx_sec, rx_seq} = e; end
    else begin tx_cap = 1; {tx_ns, tx_sec, tx_seq} = e; end
  endtask

  function automatic logic [77:0] mk(input int i);
    return {14'(i * 3 + 1), 16'(i * 257 + 5), 32'(32'h1000_0000 + i * 7), 16'(16'h4000 + i)};
  endfunction

  task automatic capture(input int d, input logic [77:0] e);
    int sz = qsize(d);
    @(negedge clk);
    drive_cap(d, e);
    @(negedge clk);
    rx_cap = 0; tx_cap = 0;
    model_cap(d, e, sz);
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] data);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 data = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] v);
    @(negedge clk);
    reg_addr = a; reg_wdata = v; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic pop_check(input int d, input string tag);
    logic [15:0] v;
    for (int w = 0; w < 5; w++) begin
      rd(4'(5 * d + w), v);
      chk(v === exp_word(d, w), tag, v, exp_word(d, w));
    end
    if (d == 0 && q_rx.size() > 0) void'(q_rx.pop_front());
    if (d == 1 && q_tx.size() > 0) void'(q_tx.pop_front());
  endtask

  task automatic check_counts(input string tag);
    logic [15:0] v, e;
    e = {8'(q_tx.size()), 8'(q_rx.size())};
    rd(4'd12, v);
    chk(v === e, tag, v, e);
  endtask

  task automatic check_status(input string tag);
    logic [15:0] v, e;
    e = {12'h0, exp_status()};
    rd(4'd10, v);
    chk(v === e, tag, v, e);
    ovf = 0;
  endtask

  task automatic check_irq(input string tag);
    logic e;
    @(negedge clk);
    #1 e = |(exp_status() & en);
    chk(irq === e, tag, irq, e);
  endtask

  task automatic capture_pop(input int d, input logic [77:0] e, input string tag);
    int sz = qsize(d);
    logic [15:0] v;
    @(negedge clk);
    drive_cap(d, e);
    reg_addr = 4'(5 * d + 4); reg_rd = 1;
    #1 v = reg_rdata;
    chk(v === exp_word(d, 4), tag, v, exp_word(d, 4));
    @(negedge clk);
    rx_cap = 0; tx_cap = 0; reg_rd = 0;
    if (sz > 0) begin
      if (d == 0) void'(q_rx.pop_front()); else void'(q_tx.pop_front());
    end
    model_cap(d, e, sz);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=%0d exp=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    int n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R10 reset state
    check_counts("R10 counts");
    check_status("R10 status");
    check_irq("R10 irq");
    rd(4'd11, v); chk(v === 16'h0, "R10 enable", v, 16'h0);
    rd(4'd0, v); chk(v === 16'h0, "R3 empty rx word", v, 16'h0);

    // R1 R5 interleaved captures
    capture(0, mk(n)); n++;
    capture(1, mk(n)); n++;
    capture(0, mk(n)); n++;
    capture(1, mk(n)); n++;
    capture(0, mk(n)); n++;
    check_counts("R5 counts 3/2");
    check_status("R7 avail levels");

    // R4 reading non-pop words changes nothing; R3 valid flag
    rd(4'd0, v); chk(v[15] === 1'b1, "R3 valid flag", v, exp_word(0, 0));
    rd(4'd2, v);
    rd(4'd6, v);
    check_counts("R4 no pop on other words");

    // R2 full entry compare
    pop_check(0, "R2 rx head words");
    pop_check(1, "R2 tx head words");
    check_counts("R1 after pops");

    // R6 fill to full and overflow
    while (q_rx.size() < DEPTH) begin capture(0, mk(n)); n++; end
    capture(0, mk(n)); n++;
    check_counts("R6 count held at full");
    check_status("R6 R7 overflow rx");
    check_status("R7 cleared by read");

    // R8 interrupt masking
    wr(4'd11, 16'h0002); en = 4'h2;
    check_irq("R8 tx avail enabled");
    rd(4'd11, v); chk(v === 16'h2, "R8 enable readback", v, 16'h2);
    wr(4'd11, 16'h0008); en = 4'h8;
    check_irq("R8 no tx ovf yet");
    while (q_tx.size() < DEPTH) begin capture(1, mk(n)); n++; end
    capture(1, mk(n)); n++;
    check_irq("R8 tx ovf irq");
    check_status("R6 tx overflow");
    check_irq("R8 irq drops after clear");

    // R11 simultaneous capture and pop
    capture_pop(0, mk(n), "R11 full: head seq"); n++;
    check_counts("R11 full drop count");
    check_status("R11 full drop ovf");
    capture_pop(0, mk(n), "R11 not full: head seq"); n++;
    check_counts("R11 count unchanged");
    check_status("R11 no ovf");

    // R1 drain with order check and pointer wrap
    while (q_rx.size() > 0) pop_check(0, "R1 rx order");
    for (int k = 0; k < 6; k++) begin capture(0, mk(n)); n++; pop_check(0, "R1 wrap"); end
    rd(4'd4, v); chk(v === 16'h0, "R3 empty seq word", v, 16'h0);
    check_counts("R4 pop of empty");
    check_status("R7 rx avail cleared");

    // R9 hard reset with simultaneous capture
    capture(0, mk(n)); n++;
    capture(0, mk(n)); n++;
    capture(1, mk(n)); n++;
    @(negedge clk);
    drive_cap(1, mk(n)); n++;
    reg_addr = 4'd13; reg_wdata = 16'h0001; reg_wr = 1;
    @(negedge clk);
    tx_cap = 0; reg_wr = 0;
    q_rx.delete(); q_tx.delete(); ovf = 0;
    check_counts("R9 queues emptied");
    rd(4'd5, v); chk(v === 16'h0, "R9 tx word zero", v, 16'h0);
    rd(4'd11, v); chk(v === 16'h8, "R9 enable kept", v, 16'h8);
    check_status("R9 status cleared");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule